// File: doc/BRIEF.md
# Instruction Class Decoder

This block sorts a 32-bit instruction word into one of fourteen instruction classes. These include the system trap, the coprocessor register moves in each direction, coprocessor operations and undefined encodings, coprocessor memory transfers, branches, and multi-register transfers. Also covered are single load/store, status-register reads and writes, ALU operations, halfword transfers, swap, and multiply. The class is chosen by a priority tree that looks only at bits 27..20 and 7..4 of the word. Several irregular corners of that tree fall into the undefined class.

An upstream fetch stage presents a word with a valid strobe. The block returns the class in two forms: a 4-bit code and a one-hot vector, each with a valid flag. With the default `PIPE_OUT = 1`, the class is registered and appears one cycle after the input. The registered class only loads when the strobe is high, so it holds its value through idle cycles. With `PIPE_OUT = 0` the decode is purely combinational. Condition codes and operand fields are left to later stages.

Top module: `insn_class_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_class` is the undefined code 3, with `out_onehot` equal to 1<<3.
- R2: `out_valid` equals `in_valid` of the previous clock cycle.
- R3: A cycle with `in_valid` low leaves `out_class` and `out_onehot` unchanged, whatever `in_word` holds.
- R4: `out_onehot` has exactly one bit set, at the position given by `out_class`. The codes are: 0 trap, 1 coprocessor-to-register, 2 register-to-coprocessor, 3 undefined/coprocessor operation, 4 coprocessor memory transfer, 5 branch, 6 multi-register transfer, 7 single transfer, 8 status write, 9 status read, 10 ALU, 11 halfword transfer, 12 swap, 13 multiply.
- R5: With bits 27, 26 and 25 all set, the class depends on bits 24, 4 and 20. Bit 24 set gives trap (0). Otherwise, bit 4 set gives coprocessor-to-register (1) if bit 20 is set and register-to-coprocessor (2) if bit 20 is clear. Bit 4 clear gives undefined (3).
- R6: If bit 27 is set and bit 26 is set, bit 25 clear gives coprocessor memory transfer (4). If bit 27 is set and bit 26 is clear, bit 25 set gives branch (5) and bit 25 clear gives multi-register transfer (6).
- R7: Bit 27 clear with bit 26 set gives single transfer (7), except that bits 25 and 4 both set give undefined (3).
- R8: Bits 27..26 = 00 with bit 25 set give ALU (10), unless bit 24 is set and bits 23 and 20 are clear. In that case the class is status write (8) if bit 21 is set and undefined (3) if it is clear.
- R9: Bits 27..24 = 0001 with bits 7 and 4 set are decoded as follows. If bit 20 is set: halfword (11) when bit 6 or bit 5 is set, otherwise undefined. If bit 20 is clear: undefined if bit 6 is set; else halfword if bit 5 is set; else swap (12) if bits 23 and 21 are clear; else undefined.
- R10: Bits 27..24 = 0001 with bit 7 clear or bit 4 clear give ALU (10). The one exception is bits 7, 6, 5, 4, 23 and 20 all clear, which gives status write (8) if bit 21 is set and status read (9) if it is clear.
- R11: Bits 27..24 = 0000 with bits 7 and 4 set are decoded as follows. If bit 6 or bit 5 is set: halfword (11) when bits 20 and 6 are both set or when bit 6 is clear and bit 5 is set, otherwise undefined. If bits 6 and 5 are both clear: multiply (13) when bit 23 is set or bit 22 is clear, otherwise undefined.
- R12: Any other word with bits 27..24 = 0000 gives ALU (10). Bits 31..28, 19..8 and 3..0 never affect the class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking `in_word` as present |
| in_word | input | 32 | Instruction word to classify |
| out_valid | output | 1 | Class outputs belong to a strobed word |
| out_class | output | 4 | Encoded class code |
| out_onehot | output | 14 | One-hot class, bit index equals code |

## Verification
The assertions check the following on every cycle: valid latency, class hold during idle cycles, the agreement of the one-hot vector with the code, and the trap and branch corners of the tree. The irregular corners of the tree can only be shown by the bench. These are the halfword/swap/multiply/status splits and the undefined holes between them. The bench sweeps all 4096 combinations of the twelve deciding bits, fills the ignored bits with fresh random values for each word, and compares against a pattern table written independently.

// File: rtl/insn_class_pkg.sv
package insn_class_pkg;

  localparam int NUM_CLASSES = 14;
  localparam int CLS_W       = $clog2(NUM_CLASSES);

  typedef enum logic [CLS_W-1:0] {
    CLS_TRAP       = 4'd0,
    CLS_CP_TO_REG  = 4'd1,
    CLS_REG_TO_CP  = 4'd2,
    CLS_UNDEF      = 4'd3,
    CLS_CP_MEM     = 4'd4,
    CLS_BRANCH     = 4'd5,
    CLS_MULTI_XFER = 4'd6,
    CLS_XFER       = 4'd7,
    CLS_STATUS_WR  = 4'd8,
    CLS_STATUS_RD  = 4'd9,
    CLS_ALU        = 4'd10,
    CLS_HALF_XFER  = 4'd11,
    CLS_SWAP       = 4'd12,
    CLS_MUL        = 4'd13
  } class_e;

endpackage

// File: rtl/icd_tree.sv
module icd_tree
  import insn_class_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output class_e            cls
);

  logic b27, b26, b25, b24, b23, b22, b21, b20;
  logic b7, b6, b5, b4;

  assign {b27, b26, b25, b24, b23, b22, b21, b20} = word[27:20];
  assign {b7, b6, b5, b4} = word[7:4];

  class_e cp_top, mem_top, misc_top, ext_top, base_top;

  // bit 27 set: trap, coprocessor, branch, multi-register
  always_comb begin
    if (b26) begin
      if (!b25)      cp_top = CLS_CP_MEM;
      else if (b24)  cp_top = CLS_TRAP;
      else if (b4)   cp_top = b20 ? CLS_CP_TO_REG : CLS_REG_TO_CP;
      else           cp_top = CLS_UNDEF;
    end else begin
      cp_top = b25 ? CLS_BRANCH : CLS_MULTI_XFER;
    end
  end

  // 01x: single transfers with the register-shift hole
  always_comb begin
    mem_top = (b25 && b4) ? CLS_UNDEF : CLS_XFER;
  end

  // 001: immediate ALU and status write
  always_comb begin
    if (b24 && !b23 && !b20) misc_top = b21 ? CLS_STATUS_WR : CLS_UNDEF;
    else                     misc_top = CLS_ALU;
  end

  // 0001: halfword, swap, status
  always_comb begin
    ext_top = CLS_ALU;
    if (b7 && b4) begin
      if (b20)      ext_top = (b6 || b5) ? CLS_HALF_XFER : CLS_UNDEF;
      else if (b6)  ext_top = CLS_UNDEF;
      else if (b5)  ext_top = CLS_HALF_XFER;
      else if (!b23 && !b21) ext_top = CLS_SWAP;
      else          ext_top = CLS_UNDEF;
    end else if (!b7 && !b4 && !b23 && !b20 && !b6 && !b5) begin
      ext_top = b21 ? CLS_STATUS_WR : CLS_STATUS_RD;
    end
  end

  // 0000: multiply and halfword
  always_comb begin
    base_top = CLS_ALU;
    if (b7 && b4) begin
      if (b6 || b5)
        base_top = ((b20 && b6) || (!b6 && b5)) ? CLS_HALF_XFER : CLS_UNDEF;
      else
        base_top = (b23 || !b22) ? CLS_MUL : CLS_UNDEF;
    end
  end

  always_comb begin
    if (b27)      cls = cp_top;
    else if (b26) cls = mem_top;
    else if (b25) cls = misc_top;
    else if (b24) cls = ext_top;
    else          cls = base_top;
  end

endmodule

// File: rtl/icd_stage.sv
module icd_stage
  import insn_class_pkg::*;
#(
  parameter bit PIPE_OUT = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   d_valid,
  input  class_e d_cls,
  output logic   q_valid,
  output class_e q_cls
);

  generate
    if (PIPE_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q_valid <= 1'b0;
          q_cls   <= CLS_UNDEF;
        end else begin
          q_valid <= d_valid;
          if (d_valid) q_cls <= d_cls;
        end
      end
    end else begin : g_comb
      assign q_valid = d_valid;
      assign q_cls   = d_cls;
    end
  endgenerate

endmodule

// File: rtl/icd_onehot.sv
module icd_onehot
  import insn_class_pkg::*;
#(
  parameter int N = NUM_CLASSES
) (
  input  class_e       cls,
  output logic [N-1:0] vec
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign vec[i] = (cls == class_e'(i));
    end
  endgenerate

endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
  import insn_class_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter bit PIPE_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [WORD_W-1:0]      in_word,
  output logic                   out_valid,
  output logic [CLS_W-1:0]       out_class,
  output logic [NUM_CLASSES-1:0] out_onehot
);

  class_e dec_cls;
  class_e stg_cls;

  icd_tree #(.WORD_W(WORD_W)) tree_i (
    .word (in_word),
    .cls  (dec_cls)
  );

  icd_stage #(.PIPE_OUT(PIPE_OUT)) stage_i (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_cls   (dec_cls),
    .q_valid (out_valid),
    .q_cls   (stg_cls)
  );

  icd_onehot #(.N(NUM_CLASSES)) oh_i (
    .cls (stg_cls),
    .vec (out_onehot)
  );

  assign out_class = stg_cls;

  AST_ONEHOT_MATCH: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_onehot) == 1) && (out_onehot == (NUM_CLASSES'(1) << out_class))); // R4

  generate
    if (PIPE_OUT) begin : g_chk
      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_class) && $stable(out_onehot))); // R3
      AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_word[27:24] == 4'hF)) |=> (out_class == CLS_TRAP)); // R5
      AST_BRANCH_CLASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_word[27:25] == 3'b101)) |=> (out_class == CLS_BRANCH)); // R6
    end
  endgenerate

endmodule

// File: tb/insn_class_decoder_tb.sv
`timescale 1ns/1ps
module insn_class_decoder_tb_top;

  localparam int NC = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   in_word = '0;
  logic          out_valid;
  logic [3:0]    out_class;
  logic [NC-1:0] out_onehot;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  insn_class_decoder #(.WORD_W(32), .PIPE_OUT(1'b1)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_class  (out_class),
    .out_onehot (out_onehot)
  );

  // key = {w[27:20], w[7:4]}; first matching pattern wins
  function automatic logic [3:0] ref_class(input logic [11:0] k);
    casez (k)
      12'b1111_????_????: return 4'd0;
      12'b1110_???1_???1: return 4'd1;
      12'b1110_???0_???1: return 4'd2;
      12'b1110_????_????: return 4'd3;
      12'b110?_????_????: return 4'd4;
      12'b101?_????_????: return 4'd5;
      12'b100?_????_????: return 4'd6;
      12'b011?_????_???1: return 4'd3;
      12'b01??_????_????: return 4'd7;
      12'b0011_0?10_????: return 4'd8;
      12'b0011_0?00_????: return 4'd3;
      12'b001?_????_????: return 4'd10;
      12'b0001_???1_11?1: return 4'd11;
      12'b0001_???1_1011: return 4'd11;
      12'b0001_???1_1001: return 4'd3;
      12'b0001_???0_11?1: return 4'd3;
      12'b0001_???0_1011: return 4'd11;
      12'b0001_0?00_1001: return 4'd12;
      12'b0001_???0_1001: return 4'd3;
      12'b0001_0?10_0000: return 4'd8;
      12'b0001_0?00_0000: return 4'd9;
      12'b0001_????_????: return 4'd10;
      12'b0000_???1_11?1: return 4'd11;
      12'b0000_???0_11?1: return 4'd3;
      12'b0000_????_1011: return 4'd11;
      12'b0000_1???_1001: return 4'd13;
      12'b0000_?0??_1001: return 4'd13;
      12'b0000_????_1001: return 4'd3;
      default:            return 4'd10;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] k);
    if (k[11:9] == 3'b111)       return "R5";
    if (k[11])                   return "R6";
    if (k[10])                   return "R7";
    if (k[9])                    return "R8";
    if (k[8] && k[3] && k[0])    return "R9";
    if (k[8])                    return "R10";
    if (k[3] && k[0])            return "R11";
    return "R12";
  endfunction

  task automatic check(input string rq, input logic v, input logic [3:0] c,
                       input logic [NC-1:0] oh, input logic [3:0] exp_c, input logic exp_v);
    logic [NC-1:0] exp_oh;
    exp_oh = NC'(1) << exp_c;
    n_run++;
    if (v !== exp_v || c !== exp_c || oh !== exp_oh) begin
      n_fail++;
      $display("FAIL %s: valid=%0b class=%0d onehot=%h expected valid=%0b class=%0d onehot=%h",
               rq, v, c, oh, exp_v, exp_c, exp_oh);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [3:0] last;
    @(negedge clk);
    @(negedge clk);
    check("R1", out_valid, out_class, out_onehot, 4'd3, 1'b0); // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check("R1", out_valid, out_class, out_onehot, 4'd3, 1'b0); // R1 first cycle after
    last = 4'd3;
    for (int k = 0; k < 4096; k++) begin
      logic [31:0] w;
      logic [11:0] key;
      logic [3:0]  e;
      key = 12'(k);
      w = $urandom();
      w[27:20] = key[11:4];
      w[7:4]   = key[3:0];
      e = ref_class(key);
      in_valid = 1'b1;
      in_word  = w;
      @(negedge clk);
      check(req_of(key), out_valid, out_class, out_onehot, e, 1'b1); // R2 R4 plus tree req
      last = e;
      if (k % 16 == 5) begin
        in_valid = 1'b0;
        in_word  = ~w; // R3: idle word must not disturb the held class
        @(negedge clk);
        check("R3", out_valid, out_class, out_onehot, last, 1'b0);
      end
    end
    // R12: ignored bits, same key with opposite fillers
    for (int j = 0; j < 32; j++) begin
      logic [31:0] w;
      logic [3:0]  e;
      w = $urandom();
      e = ref_class({w[27:20], w[7:4]});
      in_valid = 1'b1;
      in_word  = w | 32'hF00F_FF0F;
      @(negedge clk);
      check("R12", out_valid, out_class, out_onehot, e, 1'b1);
      in_word  = w & ~32'hF00F_FF0F;
      @(negedge clk);
      check("R12", out_valid, out_class, out_onehot, e, 1'b1);
    end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule